// File: doc/BRIEF.md
# Soft-Start Sequencer with Shutdown

This block is the digital start-up controller of a voltage-mode buck regulator. It keeps the converter parked, with the oscillator stopped and both power-switch gate drives off, until the supply monitor reports a good rail and the external run request is high. Once both hold, it runs a fixed timed sequence. First comes a settling wait with the oscillator running. Next, a short interval clamps the compensation node so the loop filter discharges. Last comes a ramp, in which a digital reference offset (fed to a DAC outside this block) counts down from full scale to zero while the gate drivers are enabled.

The supply-good and run-request inputs are asynchronous to the block clock, so each one passes through a two-stage synchronizer first. If either input falls at any point in the sequence, including after it completes, the block returns to its parked state. When both inputs are high again, it starts the whole sequence over from the settling wait. All phase lengths are parameters; the defaults are 1024 settling cycles, 24 clamp cycles and an 11-bit offset, which gives a 2048-cycle ramp.

Top module: `softstart_seq`

## Requirements
- R1: While `por_ok` or `run_req` is low (after synchronization), the block is parked: `osc_en`, `gate_en`, `comp_clamp` and `ss_done` are 0 and `fb_offset` is all ones (full scale).
- R2: Each input passes two synchronizer flops and the phase register. When both inputs are set high before clock edge 1, the outputs first leave the parked values after edge 3.
- R3: The settling phase lasts SETTLE_CYC clock cycles (default 1024). During it `osc_en` is 1, `gate_en`, `comp_clamp` and `ss_done` are 0, and `fb_offset` is full scale.
- R4: Directly after settling, `comp_clamp` is 1 for exactly CLAMP_CYC cycles (default 24). During this phase `osc_en` is 1, `gate_en` is 0 and `fb_offset` is full scale.
- R5: Directly after the clamp, the ramp lasts 2^OFS_W cycles (default 2048). During the ramp `gate_en` is 1 and `comp_clamp` is 0. `fb_offset` (OFS_W bits, default 11) starts at 2^OFS_W-1 and drops by exactly one each cycle, reaching 0 in the last ramp cycle.
- R6: After the ramp, the block stays in the run phase: `ss_done` is 1, `fb_offset` is 0, and `osc_en` and `gate_en` are 1.
- R7: If either input is low at a clock edge in any phase, including for a single cycle, the block is parked after the third edge. When both inputs are high again, the full sequence restarts from settling.
- R8: `comp_clamp` and `gate_en` are never 1 together, and `ss_done` is only 1 while `gate_en` is 1 and `fb_offset` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (the switching oscillator clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supply-good flag, asynchronous |
| run_req | input | 1 | Run request (low means shutdown), asynchronous |
| osc_en | output | 1 | Oscillator enable |
| gate_en | output | 1 | Enable for both gate drivers; 0 holds them off |
| comp_clamp | output | 1 | Clamp the compensation node |
| fb_offset | output | OFS_W | Soft-start offset code for the feedback DAC |
| ss_done | output | 1 | Soft start complete |

## Verification
The bench uses a reduced configuration: 8 settling cycles, 3 clamp cycles and a 3-bit offset. In that configuration it compares every output on every cycle of a full sequence against an arithmetic timeline, so a wrong phase length, a wrong ramp step or a wrong synchronizer depth each shows up at a specific cycle. It then sweeps the fault point across every cycle of the sequence, alternating which input drops, which shows whether each phase re-arms and whether the restart is clean. Holding only one input high confirms that a single input never starts the sequence. A one-cycle shutdown pulse during the run phase shows that a short glitch still forces a complete restart.

// File: rtl/ss_pkg.sv
package ss_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_CLAMP  = 3'd2,
    PH_RAMP   = 3'd3,
    PH_RUN    = 3'd4
  } ss_phase_e;

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int N_BITS = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] d_async,
  output logic [N_BITS-1:0] q_sync
);

  genvar b;
  generate
    for (b = 0; b < N_BITS; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_async[b]};
      end
      assign q_sync[b] = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ss_phase_fsm.sv
module ss_phase_fsm
  import ss_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int CLAMP_CYC  = 24,
  parameter int RAMP_CYC   = 2048,
  parameter int CNT_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  output ss_phase_e        phase,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [CNT_W-1:0] CLAMP_LD  = CNT_W'(CLAMP_CYC - 1);
  localparam logic [CNT_W-1:0] RAMP_LD   = CNT_W'(RAMP_CYC - 1);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  ss_phase_e        phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             upd_en;

  assign cnt_zero = (cnt_q == '0);

  // next-state and counter reload
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!arm) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_d = PH_SETTLE;
          cnt_d   = SETTLE_LD;
        end
        PH_SETTLE: begin
          if (cnt_zero) begin
            phase_d = PH_CLAMP;
            cnt_d   = CLAMP_LD;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_CLAMP: begin
          if (cnt_zero) begin
            phase_d = PH_RAMP;
            cnt_d   = RAMP_LD;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
        PH_RAMP: begin
          if (cnt_zero) phase_d = PH_RUN;
          else          cnt_d   = cnt_q - ONE;
        end
        PH_RUN: begin
          phase_d = PH_RUN;
        end
        default: begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end
      endcase
    end
  end

  assign upd_en = (phase_d != phase_q) || (cnt_d != cnt_q);

  // state register with explicit enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (upd_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase = phase_q;
  assign cnt   = cnt_q;

endmodule

// File: rtl/ss_out_decode.sv
module ss_out_decode
  import ss_pkg::*;
#(
  parameter int OFS_W = 11,
  parameter int CNT_W = 11
) (
  input  ss_phase_e        phase,
  input  logic [CNT_W-1:0] cnt,
  output logic             osc_en,
  output logic             gate_en,
  output logic             comp_clamp,
  output logic [OFS_W-1:0] fb_offset,
  output logic             ss_done
);

  always_comb begin
    osc_en     = 1'b0;
    gate_en    = 1'b0;
    comp_clamp = 1'b0;
    ss_done    = 1'b0;
    fb_offset  = '1;
    unique case (phase)
      PH_IDLE: ;
      PH_SETTLE: osc_en = 1'b1;
      PH_CLAMP: begin
        osc_en     = 1'b1;
        comp_clamp = 1'b1;
      end
      PH_RAMP: begin
        osc_en    = 1'b1;
        gate_en   = 1'b1;
        fb_offset = cnt[OFS_W-1:0];
      end
      PH_RUN: begin
        osc_en    = 1'b1;
        gate_en   = 1'b1;
        ss_done   = 1'b1;
        fb_offset = '0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int CLAMP_CYC  = 24,
  parameter int OFS_W      = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_ok,
  input  logic             run_req,
  output logic             osc_en,
  output logic             gate_en,
  output logic             comp_clamp,
  output logic [OFS_W-1:0] fb_offset,
  output logic             ss_done
);

  localparam int RAMP_CYC = 1 << OFS_W;
  localparam int MAX_SC   = (SETTLE_CYC > CLAMP_CYC) ? SETTLE_CYC : CLAMP_CYC;
  localparam int MAX_CYC  = (MAX_SC > RAMP_CYC) ? MAX_SC : RAMP_CYC;
  localparam int CNT_W    = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  logic [1:0]       in_sync;
  logic             arm;
  ss_phase_e        phase;
  logic [CNT_W-1:0] cnt;

  ss_sync #(.N_BITS(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({run_req, por_ok}),
    .q_sync  (in_sync)
  );

  assign arm = &in_sync;

  ss_phase_fsm #(
    .SETTLE_CYC (SETTLE_CYC),
    .CLAMP_CYC  (CLAMP_CYC),
    .RAMP_CYC   (RAMP_CYC),
    .CNT_W      (CNT_W)
  ) u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (arm),
    .phase (phase),
    .cnt   (cnt)
  );

  ss_out_decode #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_dec (
    .phase      (phase),
    .cnt        (cnt),
    .osc_en     (osc_en),
    .gate_en    (gate_en),
    .comp_clamp (comp_clamp),
    .fb_offset  (fb_offset),
    .ss_done    (ss_done)
  );

endmodule

// File: rtl/ss_seq_checker.sv
module ss_seq_checker #(
  parameter int OFS_W = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             por_ok,
  input logic             run_req,
  input logic             osc_en,
  input logic             gate_en,
  input logic             comp_clamp,
  input logic [OFS_W-1:0] fb_offset,
  input logic             ss_done
);

  assert_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!gate_en && !comp_clamp && !ss_done && (fb_offset == '1)));

  assert_clamp_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(comp_clamp) |-> ($past(osc_en) && (fb_offset == '1)));

  assert_ramp_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_en) |-> (fb_offset == '1 && !ss_done));

  assert_ramp_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && !ss_done && $past(gate_en && !ss_done))
      |-> (fb_offset == OFS_W'($past(fb_offset) - 1'b1)));

  assert_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_done) |-> ($past(fb_offset) == '0 && $past(gate_en)));

  assert_fault_por_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!por_ok, 3) |-> !osc_en);

  assert_fault_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_req, 3) |-> !osc_en);

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(comp_clamp && gate_en));

  assert_done_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ss_done |-> (gate_en && fb_offset == '0));

endmodule

bind softstart_seq ss_seq_checker #(.OFS_W(OFS_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_ok     (por_ok),
  .run_req    (run_req),
  .osc_en     (osc_en),
  .gate_en    (gate_en),
  .comp_clamp (comp_clamp),
  .fb_offset  (fb_offset),
  .ss_done    (ss_done)
);

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;

  localparam int S  = 8;
  localparam int C  = 3;
  localparam int W  = 3;
  localparam int R  = 1 << W;
  localparam int LAT = 3;
  localparam int TOTAL = LAT + S + C + R;
  localparam logic [W-1:0] FULL = '1;

  logic clk, rst_n, por_ok, run_req;
  logic osc_en, gate_en, comp_clamp, ss_done;
  logic [W-1:0] fb_offset;

  int total_chk = 0;
  int bad_chk   = 0;

  softstart_seq #(.SETTLE_CYC(S), .CLAMP_CYC(C), .OFS_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .run_req(run_req),
    .osc_en(osc_en), .gate_en(gate_en), .comp_clamp(comp_clamp),
    .fb_offset(fb_offset), .ss_done(ss_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // expected {osc, gate, clamp, done, offset} after edge e since both went high
  function automatic logic [W+3:0] model(int e);
    if (e < LAT)               return {4'b0000, FULL};
    if (e < LAT + S)           return {4'b1000, FULL};
    if (e < LAT + S + C)       return {4'b1010, FULL};
    if (e < LAT + S + C + R)   return {4'b1100, W'(R - 1 - (e - LAT - S - C))};
    return {4'b1101, {W{1'b0}}};
  endfunction

  function automatic string tag_of(int e);
    if (e < LAT)             return "R1";
    if (e == LAT)            return "R2";
    if (e < LAT + S)         return "R3";
    if (e < LAT + S + C)     return "R4";
    if (e < LAT + S + C + R) return "R5";
    return "R6";
  endfunction

  task automatic check(string tag, logic [W+3:0] exp);
    logic [W+3:0] act;
    act = {osc_en, gate_en, comp_clamp, ss_done, fb_offset};
    total_chk++;
    if (act !== exp) begin
      bad_chk++;
      $display("FAIL %s t=%0t act=%b exp=%b", tag, $time, act, exp);
    end
  endtask

  task automatic step_check(string tag, logic [W+3:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic raise_both();
    @(negedge clk);
    por_ok  = 1'b1;
    run_req = 1'b1;
  endtask

  task automatic run_from_start(int n);
    for (int i = 1; i <= n; i++) step_check(tag_of(i), model(i));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad_chk++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_ok = 1'b0; run_req = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {4'b0000, FULL});
    rst_n = 1'b1;

    // R1: only one input high never starts the sequence
    por_ok = 1'b1;
    for (int i = 0; i < 10; i++) step_check("R1", {4'b0000, FULL});
    por_ok = 1'b0; run_req = 1'b1;
    for (int i = 0; i < 10; i++) step_check("R1", {4'b0000, FULL});
    run_req = 1'b0;
    repeat (4) @(negedge clk);

    // full sequence, every cycle checked (R2..R6)
    raise_both();
    run_from_start(TOTAL + 6);

    // R7: one-cycle shutdown pulse in run phase, then full restart
    @(negedge clk); run_req = 1'b0;
    @(negedge clk); run_req = 1'b1;
    check("R7", model(TOTAL + 6));
    step_check("R7", model(TOTAL + 6));
    for (int k = 3; k <= TOTAL + 3; k++) step_check("R7", model(k - 1));

    por_ok = 1'b0; run_req = 1'b0;
    repeat (5) @(negedge clk);

    // R7: sweep fault point over every cycle, alternating the dropped input
    for (int d = 1; d <= TOTAL + 1; d++) begin
      raise_both();
      run_from_start(d);
      if (d % 2 == 1) por_ok = 1'b0;
      else            run_req = 1'b0;
      step_check("R7", model(d + 1));
      step_check("R7", model(d + 2));
      step_check("R7", {4'b0000, FULL});
      for (int i = 0; i < 3; i++) step_check("R7", {4'b0000, FULL});
      por_ok = 1'b0; run_req = 1'b0;
      repeat (3) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

endmodule